// File: doc/BRIEF.md
# Serial Display Writer with Command/Data Select

This block is a transmit-only four-wire serial master for a display controller. It drives chip select, serial clock, serial data out and a command/data select line. The select line is set for every byte: low while a command byte is shifted, high while a data byte is shifted. There is no serial input line; the link only writes.

A producer hands over one tagged byte at a time on a valid/ready interface. Each byte carries a data/command tag and an end-of-message marker. A message is normally one or more command bytes followed by zero or more data bytes, up to at least 160. A one-byte look-ahead register takes the next byte while the current one is shifting. The whole message then goes out as a single transfer: the clock runs with no gap between bytes, and chip select stays low until the marked final byte has completed. Two sticky flags, cleared only by reset, report misuse. One is an underrun, when the next byte is missing at a byte boundary. The other is a command byte that follows data in the same message.

Top module: `spi_disp_writer`

## Requirements
- R1: After reset, cs_no is 1, sck_o is 0, underrun_o is 0, order_err_o is 0 and in_ready_o is 1.
- R2: Bytes are shifted most-significant bit first with idle-low clock timing. mosi_o changes only while sck_o is low, and the receiver samples it on each rising edge of sck_o.
- R3: dc_o is 0 for a byte tagged command (in_is_data_i = 0) and 1 for a byte tagged data (in_is_data_i = 1). It holds one value from the first rising edge of a byte through the rising edge of its eighth bit. It changes only together with a falling sck_o edge or the falling edge of cs_no.
- R4: While cs_no is low, every low and every high phase of sck_o lasts exactly HALF_DIV system clocks, including the phases between bytes.
- R5: cs_no falls together with the start of the first byte's low phase. It rises exactly HALF_DIV system clocks after the final falling edge of sck_o, and only after a byte accepted with in_last_i = 1, so a message is one unbroken transfer.
- R6: A byte is accepted on a clock where in_valid_i and in_ready_o are both 1. The look-ahead register takes the next byte during the current shift, so a producer that keeps in_valid_i high streams messages of 160 or more data bytes with no underrun.
- R7: If a byte without the end marker finishes and no next byte is waiting, underrun_o goes to 1 and stays at 1 until reset. The transfer ends with the normal HALF_DIV-clock tail and cs_no rises.
- R8: A command byte that follows a data byte in the same message sets order_err_o to 1 until reset. That byte is still sent, with dc_o at 0.
- R9: While cs_no is high, sck_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Tagged byte offered |
| in_ready_o | output | 1 | Look-ahead register can take a byte |
| in_byte_i | input | 8 | Byte value |
| in_is_data_i | input | 1 | 1 = data byte, 0 = command byte |
| in_last_i | input | 1 | Final byte of the message |
| sck_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data out, MSB first |
| cs_no | output | 1 | Chip select, active low |
| dc_o | output | 1 | Command (0) / data (1) select |
| underrun_o | output | 1 | Sticky: next byte missing at a byte boundary |
| order_err_o | output | 1 | Sticky: command byte after data in one message |

## Verification
The bench decodes the serial lines in every system clock and rebuilds each byte together with its select level. It sweeps the command and data run lengths, including single-byte messages and a 160-byte data run. The most important corner is the byte boundary. A design that moves dc_o one half period early corrupts the eighth-bit sample of the previous byte. A design that waits a cycle to reload from the look-ahead register stretches one low phase and shows up as a phase-length mismatch. A design that treats each byte as its own transfer pulses cs_no between bytes, which the bench catches at any unmarked cs_no rise. Directed runs send a command byte after data and starve the producer in mid-message, so that both sticky flags and the forced end of the transfer are checked.

// File: rtl/spi_disp_pkg.sv
package spi_disp_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              is_data;
    logic              last;
    logic [BYTE_W-1:0] data;
  } tag_byte_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_TAIL
  } eng_state_e;
endpackage

// File: rtl/sdw_clk_div.sv
module sdw_clk_div #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CNT_MAX = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (cnt_q == CNT_MAX) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  // half periods of at least two system clocks
  p_tick_spacing_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/sdw_stage.sv
module sdw_stage
  import spi_disp_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      in_valid_i,
  output logic      in_ready_o,
  input  tag_byte_t in_item_i,
  input  logic      pop_i,
  output logic      out_valid_o,
  output tag_byte_t out_item_o
);
  logic      valid_q;
  tag_byte_t item_q;

  assign in_ready_o  = !valid_q || pop_i;
  assign out_valid_o = valid_q;
  assign out_item_o  = item_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      item_q  <= '0;
    end else begin
      if (in_valid_i && in_ready_o) begin
        valid_q <= 1'b1;
        item_q  <= in_item_i;
      end else if (pop_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && !pop_i |=> valid_q && $stable(item_q));
endmodule

// File: rtl/sdw_engine.sv
module sdw_engine
  import spi_disp_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      stage_valid_i,
  input  tag_byte_t stage_item_i,
  output logic      pop_o,
  output logic      busy_o,
  output logic      sck_o,
  output logic      mosi_o,
  output logic      cs_no,
  output logic      dc_o,
  output logic      underrun_o,
  output logic      order_err_o
);
  localparam int BW = $clog2(BYTE_W);

  eng_state_e        st_q;
  logic [BYTE_W-1:0] sh_q;
  logic [BW-1:0]     bit_q;
  logic              last_q, sck_q, cs_q, dc_q, seen_data_q;
  logic              underrun_q, order_err_q;
  logic              byte_end;

  assign byte_end = (st_q == ST_HIGH) && tick_i && (bit_q == '0);
  assign pop_o    = stage_valid_i && ((st_q == ST_IDLE) || (byte_end && !last_q));
  assign busy_o   = (st_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      sh_q        <= '0;
      bit_q       <= '0;
      last_q      <= 1'b0;
      sck_q       <= 1'b0;
      cs_q        <= 1'b1;
      dc_q        <= 1'b0;
      seen_data_q <= 1'b0;
      underrun_q  <= 1'b0;
      order_err_q <= 1'b0;
    end else begin
      if (pop_o) begin
        sh_q   <= stage_item_i.data;
        dc_q   <= stage_item_i.is_data;
        last_q <= stage_item_i.last;
        bit_q  <= BW'(BYTE_W - 1);
      end
      unique case (st_q)
        ST_IDLE: if (stage_valid_i) begin
          cs_q        <= 1'b0;
          seen_data_q <= stage_item_i.is_data;
          st_q        <= ST_LOW;
        end
        ST_LOW: if (tick_i) begin
          sck_q <= 1'b1;
          st_q  <= ST_HIGH;
        end
        ST_HIGH: if (tick_i) begin
          sck_q <= 1'b0;
          if (bit_q != '0) begin
            sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
            bit_q <= bit_q - 1'b1;
            st_q  <= ST_LOW;
          end else if (last_q) begin
            st_q <= ST_TAIL;
          end else if (stage_valid_i) begin
            seen_data_q <= seen_data_q | stage_item_i.is_data;
            if (seen_data_q && !stage_item_i.is_data) order_err_q <= 1'b1;
            st_q <= ST_LOW;
          end else begin
            underrun_q <= 1'b1;
            st_q       <= ST_TAIL;
          end
        end
        ST_TAIL: if (tick_i) begin
          cs_q <= 1'b1;
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign sck_o       = sck_q;
  assign mosi_o      = sh_q[BYTE_W-1];
  assign cs_no       = cs_q;
  assign dc_o        = dc_q;
  assign underrun_o  = underrun_q;
  assign order_err_o = order_err_q;

  p_idle_clock_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_q |-> !sck_q);
  p_mosi_low_phase_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mosi_o) |-> !sck_q);
  p_dc_at_boundary_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dc_q) |-> ($fell(sck_q) || $fell(cs_q)));
  p_order_sent_as_cmd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(order_err_q) |-> !dc_q);
  p_underrun_ends_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(underrun_q) |-> (st_q == ST_TAIL) && !cs_q);
endmodule

// File: rtl/spi_disp_writer.sv
module spi_disp_writer
  import spi_disp_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [BYTE_W-1:0] in_byte_i,
  input  logic              in_is_data_i,
  input  logic              in_last_i,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              cs_no,
  output logic              dc_o,
  output logic              underrun_o,
  output logic              order_err_o
);
  tag_byte_t in_item, stage_item;
  logic      stage_valid, pop, busy, tick;

  assign in_item = '{is_data: in_is_data_i, last: in_last_i, data: in_byte_i};

  sdw_stage u_stage (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .in_item_i   (in_item),
    .pop_i       (pop),
    .out_valid_o (stage_valid),
    .out_item_o  (stage_item)
  );

  sdw_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .tick_o (tick)
  );

  sdw_engine u_eng (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick),
    .stage_valid_i (stage_valid),
    .stage_item_i  (stage_item),
    .pop_o         (pop),
    .busy_o        (busy),
    .sck_o         (sck_o),
    .mosi_o        (mosi_o),
    .cs_no         (cs_no),
    .dc_o          (dc_o),
    .underrun_o    (underrun_o),
    .order_err_o   (order_err_o)
  );
endmodule

// File: tb/spi_disp_writer_tb_top.sv
module spi_disp_writer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 3;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       in_valid_i = 1'b0;
  logic [7:0] in_byte_i = '0;
  logic       in_is_data_i = 1'b0;
  logic       in_last_i = 1'b0;
  logic       in_ready_o, sck_o, mosi_o, cs_no, dc_o, underrun_o, order_err_o;

  int n_chk = 0;
  int n_bad = 0;
  bit allow_short = 0;
  logic [9:0] exp_q[$];  // {last, is_data, byte}

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  spi_disp_writer #(.HALF_DIV(HALF)) dut_i (
    .clk_i, .rst_ni, .in_valid_i, .in_ready_o, .in_byte_i, .in_is_data_i,
    .in_last_i, .sck_o, .mosi_o, .cs_no, .dc_o, .underrun_o, .order_err_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // serial monitor
  int         since = 0;
  int         nbits = 0;
  logic       psck = 1'b0, pcs = 1'b1, dc_first = 1'b0, rx_last = 1'b1;
  logic [7:0] rxb = '0;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      since++;
      if (pcs && !cs_no) begin
        since = 0;
        nbits = 0;
      end
      if (!cs_no && (sck_o != psck)) begin
        chk(since == HALF, "R4 phase length", since, HALF);
        since = 0;
        if (sck_o) begin
          rxb = {rxb[6:0], mosi_o};
          if (nbits == 0) dc_first = dc_o;
          if (nbits == 7) begin
            chk(dc_o == dc_first, "R3 dc stable in byte", dc_o, dc_first);
            if (exp_q.size() == 0) chk(0, "R6 unexpected byte", rxb, -1);
            else begin
              logic [9:0] e;
              e = exp_q.pop_front();
              chk(rxb == e[7:0], "R2 byte value", rxb, e[7:0]);
              chk(dc_o == e[8], "R3 dc level", dc_o, e[8]);
              rx_last = e[9];
            end
          end
          nbits = (nbits + 1) % 8;
        end
      end
      if (!pcs && cs_no) begin
        chk(since == HALF, "R5 tail length", since, HALF);
        chk(nbits == 0, "R5 whole bytes", nbits, 0);
        chk(rx_last || allow_short, "R5 cs only after last", rx_last, 1);
      end
      if (cs_no) chk(!sck_o, "R9 idle clock low", sck_o, 0);
    end
    psck = sck_o;
    pcs  = cs_no;
  end

  task automatic push(input logic [7:0] b, input logic is_data, input logic last);
    in_valid_i   = 1'b1;
    in_byte_i    = b;
    in_is_data_i = is_data;
    in_last_i    = last;
    exp_q.push_back({last, is_data, b});
    while (!in_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  task automatic wait_end();
    while (cs_no) @(negedge clk_i);
    while (!cs_no) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
  endtask

  task automatic send_msg(input int ncmd, input int ndata, input int m, input bit bad);
    int total;
    total = ncmd + ndata + (bad ? 1 : 0);
    for (int i = 0; i < total; i++) begin
      logic d;
      d = (i >= ncmd) && !(bad && i == total - 1);
      push(8'((m * 53 + i * 29 + 7) & 255), d, i == total - 1);
    end
    wait_end();
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(cs_no == 1'b1, "R1 cs idle", cs_no, 1);
    chk(sck_o == 1'b0, "R1 sck idle", sck_o, 0);
    chk(underrun_o == 1'b0, "R1 underrun clear", underrun_o, 0);
    chk(order_err_o == 1'b0, "R1 order_err clear", order_err_o, 0);
    chk(in_ready_o == 1'b1, "R1 ready", in_ready_o, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    chk(0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int m;
    m = 0;
    do_reset();
    // R6 sweep of command and data run lengths
    for (int nc = 1; nc <= 3; nc++) begin
      for (int k = 0; k < 4; k++) begin
        int nd;
        nd = (k == 3) ? 5 : k;
        send_msg(nc, nd, m, 0);
        m++;
        chk(underrun_o == 1'b0, "R7 no underrun", underrun_o, 0);
        chk(order_err_o == 1'b0, "R8 no order error", order_err_o, 0);
      end
    end
    // R6 long data run
    send_msg(2, 160, m, 0);
    m++;
    chk(underrun_o == 1'b0, "R6 long run no underrun", underrun_o, 0);
    chk(exp_q.size() == 0, "R6 all bytes sent", exp_q.size(), 0);
    // R8 command after data
    send_msg(1, 2, m, 1);
    m++;
    chk(order_err_o == 1'b1, "R8 order error set", order_err_o, 1);
    send_msg(1, 1, m, 0);
    m++;
    chk(order_err_o == 1'b1, "R8 order error sticky", order_err_o, 1);
    do_reset();
    // R7 starved producer
    allow_short = 1;
    push(8'hA5, 1'b0, 1'b0);
    wait_end();
    chk(underrun_o == 1'b1, "R7 underrun set", underrun_o, 1);
    chk(cs_no == 1'b1, "R7 transfer ended", cs_no, 1);
    allow_short = 0;
    do_reset();
    send_msg(1, 3, m, 0);
    chk(underrun_o == 1'b0, "R7 clear after reset", underrun_o, 0);
    chk(exp_q.size() == 0, "R6 queue drained", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule